// File: doc/BRIEF.md
# Bus-Watching Breakpoint Unit

This block watches the address, data and direction of every bus cycle of a small CPU with a 16-bit address bus. When a cycle matches the programmed values, it requests a break. An 8-bit control register selects the mode. Two 16-bit compare registers hold the values to match. A small qualifier register holds the direction to match. In the dual-address modes, each compare register is an address comparator. In the full mode, the first register matches the address and the second matches the data. The direction qualifier applies only in the two debug modes. The software-interrupt mode always ignores the access direction.

A break is requested in one of two ways. In boundary timing, a match arms a pending flag, and the request is made after the next instruction boundary. In tagged timing, every opcode fetch pushes a one-bit tag into a queue. The tag is popped when that instruction issues, and a set tag raises the request. A change-of-flow flush empties the queue, so opcodes that are fetched but never executed cannot cause a break. Tagged timing is used when the program-only bit is set, and always in software-interrupt mode.

The timing controller has two states. `S_IDLE` means nothing is pending. `S_PEND` means a boundary-timed match is waiting. It has three transitions:
- ARM (`S_IDLE` to `S_PEND`): a matching bus cycle in boundary timing while the unit is active.
- FIRE (`S_PEND` to `S_IDLE`): an instruction boundary arrives; this issues the request.
- CANCEL (`S_PEND` to `S_IDLE`): the mode is set to off; no request is issued.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, the control register, both compare registers and the qualifier register read 0, and neither `swi_req` nor `dbg_req` is asserted.
- R2: Register addresses are: 0 control, 1/2 compare 0 high/low byte, 3/4 compare 1 high/low byte, 5 qualifier. Control bits are [7:6] mode, [5] program-only, [4] range 1 and [3] range 0; bits 2..0 always read 0. Qualifier bits are [1] enable and [0] direction (1 = read); bits 7..2 read 0. All other bits read back as written.
- R3: Mode 00 never raises a request, whatever the bus does.
- R4: Mode 01 (software interrupt, dual address) raises only `swi_req`. It raises it on an executed opcode that matches either comparator. It ignores the direction qualifier and the program-only bit.
- R5: Mode 11 (debug, dual address) raises only `dbg_req`. It raises it when either comparator matches and, if the qualifier is enabled, `bus_rnw` equals the qualifier direction.
- R6: Mode 10 (debug, full) needs three things in the same bus cycle: compare 0 equals the full 16-bit address, compare 1 equals `bus_data`, and the qualifier (if enabled) is met. The range bits have no effect in this mode.
- R7: In the dual-address modes, a comparator whose range bit is 0 compares only address bits [15:8], so it covers a 256-byte page. With the range bit at 1, all 16 bits are compared.
- R8: In a debug mode with program-only 0, any matching bus cycle arms a pending break. A request pulses in the cycle after the next `instr_boundary`. A match in the same cycle as that boundary does not re-arm the break.
- R9: In tagged timing, each opcode fetch (`bus_valid` and `bus_fetch`) queues a tag, which is set when the fetch matches. A request pulses in the cycle after an `op_issue` that pops a set tag. Non-fetch accesses never cause a tagged break.
- R10: `flow_flush` empties the tag queue and discards any push or pop in the same cycle, so flushed tags never raise a request.
- R11: Each request is a one-cycle pulse per firing event, and `swi_req` and `dbg_req` are never high together.
- R12: Setting the mode to 00 while a break is pending cancels it, and no request follows a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| bus_valid | input | 1 | A CPU bus cycle is present |
| bus_fetch | input | 1 | The bus cycle is an opcode fetch |
| bus_rnw | input | 1 | Bus direction, 1 = read |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data |
| op_issue | input | 1 | The oldest fetched opcode issues |
| flow_flush | input | 1 | Change of flow; prefetched opcodes are discarded |
| instr_boundary | input | 1 | An instruction boundary is reached |
| swi_req | output | 1 | Software-interrupt request pulse |
| dbg_req | output | 1 | Debug-mode entry request pulse |

## Verification
The hardest situation to reach is a set tag sitting in a partly filled queue behind unmatched tags. It must either issue and fire, or be discarded by a flush before it reaches the head. This needs matching fetches, misses, issues and flushes interleaved in a particular order.

Directed sequences build such a queue explicitly. They also cover a pending break cancelled by a mode change. The random phase then has several ways to reach the interesting cases:
- It often places bus addresses exactly on a compare value, or on the same page as one.
- It asserts issue, flush and boundary at mixed rates.
- It reprograms the mode every hundred cycles.

Pending breaks and queued tags therefore often meet mode changes and flushes.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;
    localparam int BK_AW   = 16;
    localparam int BK_DW   = 16;
    localparam int BK_LOWW = 8;
    localparam int BK_RAW  = 3;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_SWI_DUAL = 2'b01,
        MODE_DBG_FULL = 2'b10,
        MODE_DBG_DUAL = 2'b11
    } bk_mode_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_PEND = 1'b1
    } bk_state_e;

    typedef struct packed {
        bk_mode_e           mode;
        logic               prog_only;
        logic               rng1;
        logic               rng0;
        logic [BK_AW-1:0]   cmp0;
        logic [BK_AW-1:0]   cmp1;
        logic               q_en;
        logic               q_val;
    } bk_cfg_t;

    localparam logic [BK_RAW-1:0] RA_CTRL = 3'd0;
    localparam logic [BK_RAW-1:0] RA_C0H  = 3'd1;
    localparam logic [BK_RAW-1:0] RA_C0L  = 3'd2;
    localparam logic [BK_RAW-1:0] RA_C1H  = 3'd3;
    localparam logic [BK_RAW-1:0] RA_C1L  = 3'd4;
    localparam logic [BK_RAW-1:0] RA_QUAL = 3'd5;
endpackage

// File: rtl/bkpt_regs.sv
`timescale 1ns/1ps
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BK_RAW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output bk_cfg_t           cfg
);
    bk_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            unique case (addr)
                RA_CTRL: begin
                    cfg_q.mode      <= bk_mode_e'(wdata[7:6]);
                    cfg_q.prog_only <= wdata[5];
                    cfg_q.rng1      <= wdata[4];
                    cfg_q.rng0      <= wdata[3];
                end
                RA_C0H:  cfg_q.cmp0[BK_AW-1:BK_LOWW] <= wdata;
                RA_C0L:  cfg_q.cmp0[BK_LOWW-1:0]     <= wdata;
                RA_C1H:  cfg_q.cmp1[BK_AW-1:BK_LOWW] <= wdata;
                RA_C1L:  cfg_q.cmp1[BK_LOWW-1:0]     <= wdata;
                RA_QUAL: begin
                    cfg_q.q_en  <= wdata[1];
                    cfg_q.q_val <= wdata[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL: rdata = {cfg_q.mode, cfg_q.prog_only, cfg_q.rng1, cfg_q.rng0, 3'b000};
            RA_C0H:  rdata = cfg_q.cmp0[BK_AW-1:BK_LOWW];
            RA_C0L:  rdata = cfg_q.cmp0[BK_LOWW-1:0];
            RA_C1H:  rdata = cfg_q.cmp1[BK_AW-1:BK_LOWW];
            RA_C1L:  rdata = cfg_q.cmp1[BK_LOWW-1:0];
            RA_QUAL: rdata = {6'b000000, cfg_q.q_en, cfg_q.q_val};
            default: rdata = 8'h00;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bkpt_match.sv
`timescale 1ns/1ps
module bkpt_match
    import bkpt_pkg::*;
(
    input  bk_cfg_t          cfg,
    input  logic [BK_AW-1:0] bus_addr,
    input  logic [BK_DW-1:0] bus_data,
    input  logic             bus_rnw,
    output logic             hit
);
    localparam int NCMP = 2;

    logic [BK_AW-1:0] cmp_a [NCMP];
    logic             rng_a [NCMP];
    logic [NCMP-1:0]  addr_hit;
    logic             dual;
    logic             data_hit;
    logic             rw_ok;

    assign cmp_a[0] = cfg.cmp0;
    assign cmp_a[1] = cfg.cmp1;
    assign rng_a[0] = cfg.rng0;
    assign rng_a[1] = cfg.rng1;

    assign dual = (cfg.mode == MODE_SWI_DUAL) || (cfg.mode == MODE_DBG_DUAL);

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        logic hi_eq, lo_eq;
        assign hi_eq = cmp_a[g][BK_AW-1:BK_LOWW] == bus_addr[BK_AW-1:BK_LOWW];
        assign lo_eq = cmp_a[g][BK_LOWW-1:0] == bus_addr[BK_LOWW-1:0];
        // page match when the range bit is clear in a dual-address mode
        assign addr_hit[g] = hi_eq && (lo_eq || (dual && !rng_a[g]));
    end

    assign data_hit = (bus_data == cfg.cmp1);
    assign rw_ok    = !cfg.q_en || (bus_rnw == cfg.q_val);

    always_comb begin
        unique case (cfg.mode)
            MODE_OFF:      hit = 1'b0;
            MODE_SWI_DUAL: hit = |addr_hit;
            MODE_DBG_FULL: hit = addr_hit[0] && data_hit && rw_ok;
            MODE_DBG_DUAL: hit = (|addr_hit) && rw_ok;
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bkpt_tagq.sv
`timescale 1ns/1ps
module bkpt_tagq #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  logic push_tag,
    input  logic pop,
    output logic pop_hit,
    output logic empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DEPTH-1:0] tags;
    logic [PW-1:0]    rd_p, wr_p;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign do_push = push && (cnt < CW'(DEPTH));
    assign do_pop  = pop && (cnt != '0);
    assign pop_hit = do_pop && !flush && tags[rd_p];
    assign empty   = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tags <= '0;
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else if (flush) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                tags[wr_p] <= push_tag;
                wr_p       <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
            end
            if (do_pop) begin
                rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
            end
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/bkpt_unit.sv
`timescale 1ns/1ps
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int TAG_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        bus_valid,
    input  logic        bus_fetch,
    input  logic        bus_rnw,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_data,
    input  logic        op_issue,
    input  logic        flow_flush,
    input  logic        instr_boundary,
    output logic        swi_req,
    output logic        dbg_req
);
    bk_cfg_t   cfg;
    bk_state_e state_q, state_d;
    bk_mode_e  mode_w;
    logic      hit, tag_mode, active, arm, pop_hit, tq_empty, fire;

    bkpt_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    bkpt_match u_match (
        .cfg      (cfg),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_rnw  (bus_rnw),
        .hit      (hit)
    );

    assign mode_w   = cfg.mode;
    assign active   = (mode_w != MODE_OFF);
    assign tag_mode = (mode_w == MODE_SWI_DUAL) || cfg.prog_only;
    assign arm      = bus_valid && hit && !tag_mode && active;

    bkpt_tagq #(.DEPTH(TAG_DEPTH)) u_tagq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flow_flush),
        .push     (bus_valid && bus_fetch),
        .push_tag (hit && tag_mode && active),
        .pop      (op_issue),
        .pop_hit  (pop_hit),
        .empty    (tq_empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ARM, FIRE, CANCEL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (arm) state_d = S_PEND;
            S_PEND: if (!active || instr_boundary) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign fire = active && (((state_q == S_PEND) && instr_boundary) || pop_hit);

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swi_req <= 1'b0;
            dbg_req <= 1'b0;
        end else begin
            swi_req <= fire && (mode_w == MODE_SWI_DUAL);
            dbg_req <= fire && mode_w[1];
        end
    end
endmodule

// File: rtl/bkpt_unit_chk.sv
`timescale 1ns/1ps
module bkpt_unit_chk
    import bkpt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input bk_mode_e   mode,
    input bk_state_e  state,
    input logic       instr_boundary,
    input logic       flow_flush,
    input logic       tq_empty,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       swi_req,
    input logic       dbg_req
);
    p_ctrl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && reg_addr == RA_CTRL) |-> (reg_rdata[2:0] == 3'b000));

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !(swi_req || dbg_req));

    p_swi_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swi_req |-> ($past(mode) == MODE_SWI_DUAL));

    p_dbg_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> $past(mode[1]));

    p_pend_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEND && instr_boundary && mode != MODE_OFF) |=> (swi_req || dbg_req));

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flow_flush |=> tq_empty);

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(swi_req && dbg_req));

    p_cancel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEND && mode == MODE_OFF) |=> (state == S_IDLE));
endmodule

bind bkpt_unit bkpt_unit_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode_w),
    .state          (state_q),
    .instr_boundary (instr_boundary),
    .flow_flush     (flow_flush),
    .tq_empty       (tq_empty),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_rdata      (reg_rdata),
    .swi_req        (swi_req),
    .dbg_req        (dbg_req)
);

// File: tb/bkpt_unit_tb_top.sv
`timescale 1ns/1ps
module bkpt_unit_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_rnw = 1'b0;
    logic [15:0] bus_addr = '0, bus_data = '0;
    logic        op_issue = 1'b0, flow_flush = 1'b0, instr_boundary = 1'b0;
    logic        swi_req, dbg_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of the programmed state
    bit [1:0]  m_mode;
    bit        m_prog, m_r0, m_r1, m_qen, m_qval, m_pend;
    bit [15:0] m_c0, m_c1;
    bit        mq[$];

    always #2.5 clk = ~clk;

    bkpt_unit #(.TAG_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_fetch(bus_fetch), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
        .bus_data(bus_data), .op_issue(op_issue), .flow_flush(flow_flush),
        .instr_boundary(instr_boundary), .swi_req(swi_req), .dbg_req(dbg_req)
    );

    task automatic chk(string lbl, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    function automatic bit f_hit(bit [15:0] a, bit [15:0] d, bit rnw);
        bit dual, a0, a1, rwok;
        dual = (m_mode == 2'b01) || (m_mode == 2'b11);
        a0 = (m_c0[15:8] == a[15:8]) && ((dual && !m_r0) || m_c0[7:0] == a[7:0]);
        a1 = (m_c1[15:8] == a[15:8]) && ((dual && !m_r1) || m_c1[7:0] == a[7:0]);
        rwok = !m_qen || (rnw == m_qval);
        case (m_mode)
            2'b01:   return a0 || a1;
            2'b10:   return a0 && (d == m_c1) && rwok;
            2'b11:   return (a0 || a1) && rwok;
            default: return 1'b0;
        endcase
    endfunction

    // one clock: predict, advance model, compare outputs at the falling edge
    task automatic step(string lbl);
        bit tagm, act, h, fire, es, ed, pushok;
        tagm = (m_mode == 2'b01) || m_prog;
        act  = (m_mode != 2'b00);
        h    = bus_valid && f_hit(bus_addr, bus_data, bus_rnw);
        fire = act && ((m_pend && instr_boundary) ||
                       (op_issue && !flow_flush && mq.size() > 0 && mq[0]));
        es = fire && (m_mode == 2'b01);
        ed = fire && m_mode[1];
        @(posedge clk);
        if (m_pend) begin
            if (!act || instr_boundary) m_pend = 1'b0;
        end else if (h && !tagm && act) m_pend = 1'b1;
        if (flow_flush) mq.delete();
        else begin
            pushok = mq.size() < DEPTH;
            if (op_issue && mq.size() > 0) void'(mq.pop_front());
            if (bus_valid && bus_fetch && pushok) mq.push_back(h && tagm && act);
        end
        if (reg_we) begin
            case (reg_addr)
                3'd0: begin
                    m_mode = reg_wdata[7:6]; m_prog = reg_wdata[5];
                    m_r1 = reg_wdata[4]; m_r0 = reg_wdata[3];
                end
                3'd1: m_c0[15:8] = reg_wdata;
                3'd2: m_c0[7:0]  = reg_wdata;
                3'd3: m_c1[15:8] = reg_wdata;
                3'd4: m_c1[7:0]  = reg_wdata;
                3'd5: begin m_qen = reg_wdata[1]; m_qval = reg_wdata[0]; end
                default: ;
            endcase
        end
        @(negedge clk);
        chk(lbl, {14'd0, swi_req, dbg_req}, {14'd0, es, ed});
    endtask

    task automatic idle_in();
        bus_valid = 0; bus_fetch = 0; bus_rnw = 0; op_issue = 0;
        flow_flush = 0; instr_boundary = 0; reg_we = 0;
    endtask

    task automatic wr(bit [2:0] a, bit [7:0] d);
        idle_in();
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step("cfg write");
        reg_we = 0;
    endtask

    task automatic rd(string lbl, bit [2:0] a, bit [7:0] exp);
        reg_addr = a;
        #0.5;
        chk(lbl, {8'd0, reg_rdata}, {8'd0, exp});
    endtask

    task automatic acc(string lbl, bit fetch, bit rnw, bit [15:0] a, bit [15:0] d);
        idle_in();
        bus_valid = 1; bus_fetch = fetch; bus_rnw = rnw; bus_addr = a; bus_data = d;
        step(lbl);
        idle_in();
    endtask

    task automatic issue(string lbl);
        idle_in(); op_issue = 1; step(lbl); idle_in();
    endtask

    task automatic bnd(string lbl);
        idle_in(); instr_boundary = 1; step(lbl); idle_in();
    endtask

    task automatic outs(string lbl, bit [1:0] exp);
        chk(lbl, {14'd0, swi_req, dbg_req}, {14'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        outs("R1 outputs after reset", 2'b00);
        rd("R1 ctrl after reset", 3'd0, 8'h00);
        rd("R1 cmp0 high after reset", 3'd1, 8'h00);
        rd("R1 qualifier after reset", 3'd5, 8'h00);

        // R2 register access
        wr(3'd0, 8'hFF); rd("R2 ctrl low bits read 0", 3'd0, 8'hF8);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h12); wr(3'd2, 8'h34); wr(3'd3, 8'h56); wr(3'd4, 8'h78);
        rd("R2 cmp0 high", 3'd1, 8'h12); rd("R2 cmp0 low", 3'd2, 8'h34);
        rd("R2 cmp1 high", 3'd3, 8'h56); rd("R2 cmp1 low", 3'd4, 8'h78);
        wr(3'd5, 8'hFF); rd("R2 qualifier", 3'd5, 8'h03);
        wr(3'd5, 8'h00);

        // R3 mode off
        acc("R3 fetch off", 1, 1, 16'h1234, 16'h0); issue("R3 issue off");
        outs("R3 no request when off", 2'b00);
        acc("R3 access off", 0, 1, 16'h1234, 16'h0); bnd("R3 boundary off");
        outs("R3 no request at boundary", 2'b00);

        // R4 software mode, write direction fetch with qualifier demanding read
        wr(3'd5, 8'h03);
        wr(3'd0, 8'h78);
        acc("R4 fetch cmp1", 1, 0, 16'h5678, 16'h0);
        issue("R4 issue");
        outs("R4 swi on executed match", 2'b10);
        idle_in(); step("R11 pulse ends");
        outs("R11 one-cycle swi", 2'b00);

        // R9 data access is not tagged
        acc("R9 data access", 0, 1, 16'h5678, 16'h0);
        issue("R9 issue empty queue");
        outs("R9 no break from data access", 2'b00);
        wr(3'd5, 8'h00);
        wr(3'd0, 8'hF8);
        acc("R9 tagged fetch", 1, 1, 16'h1234, 16'h0);
        acc("R9 untagged fetch", 1, 1, 16'h9999, 16'h0);
        issue("R9 issue tagged");
        outs("R9 dbg on tagged issue", 2'b01);
        issue("R9 issue untagged");
        outs("R9 no break on untagged issue", 2'b00);

        // R10 flush
        acc("R10 tagged fetch", 1, 1, 16'h1234, 16'h0);
        idle_in(); flow_flush = 1; step("R10 flush"); idle_in();
        issue("R10 issue after flush");
        outs("R10 flushed tag silent", 2'b00);

        // R8 boundary timing
        wr(3'd0, 8'hD8);
        acc("R8 match data access", 0, 0, 16'h5678, 16'h0);
        outs("R8 nothing before boundary", 2'b00);
        idle_in(); step("R8 wait");
        bnd("R8 boundary");
        outs("R8 dbg after boundary", 2'b01);
        bnd("R8 second boundary");
        outs("R11 no second pulse", 2'b00);

        // R12 cancel
        acc("R12 match", 0, 1, 16'h1234, 16'h0);
        wr(3'd0, 8'h00); wr(3'd0, 8'hD8);
        bnd("R12 boundary");
        outs("R12 cancelled break", 2'b00);

        // R7 page matching
        wr(3'd0, 8'hC0);
        acc("R7 page hit", 0, 1, 16'h12AB, 16'h0); bnd("R7 boundary");
        outs("R7 page match fires", 2'b01);
        wr(3'd0, 8'hC8);
        acc("R7 exact miss", 0, 1, 16'h12AB, 16'h0); bnd("R7 boundary exact");
        outs("R7 full compare misses", 2'b00);

        // R6 full mode
        wr(3'd0, 8'h80); wr(3'd5, 8'h03);
        acc("R6 range ignored", 0, 1, 16'h12AB, 16'h5678); bnd("R6 b0");
        outs("R6 range bits ignored", 2'b00);
        acc("R6 full hit", 0, 1, 16'h1234, 16'h5678); bnd("R6 b1");
        outs("R6 addr+data+read fires", 2'b01);
        acc("R6 wrong dir", 0, 0, 16'h1234, 16'h5678); bnd("R6 b2");
        outs("R6 direction mismatch", 2'b00);
        acc("R6 wrong data", 0, 1, 16'h1234, 16'h5679); bnd("R6 b3");
        outs("R6 data mismatch", 2'b00);

        // R5 dual debug with write qualifier
        wr(3'd0, 8'hD8); wr(3'd5, 8'h02);
        acc("R5 read access", 0, 1, 16'h1234, 16'h0); bnd("R5 b0");
        outs("R5 read blocked", 2'b00);
        acc("R5 write access", 0, 0, 16'h5678, 16'h0); bnd("R5 b1");
        outs("R5 write matches", 2'b01);

        // random phase
        for (int blk = 0; blk < 40; blk++) begin
            wr(3'd0, 8'($urandom));
            wr(3'd1, 8'($urandom)); wr(3'd2, 8'($urandom));
            wr(3'd3, 8'($urandom)); wr(3'd4, 8'($urandom));
            wr(3'd5, 8'($urandom));
            for (int c = 0; c < 100; c++) begin
                int sel;
                idle_in();
                sel = $urandom % 4;
                bus_valid = ($urandom % 3) != 0;
                bus_fetch = $urandom % 2;
                bus_rnw   = $urandom % 2;
                case (sel)
                    0: bus_addr = m_c0;
                    1: bus_addr = m_c1;
                    2: bus_addr = {m_c0[15:8], 8'($urandom)};
                    default: bus_addr = 16'($urandom);
                endcase
                bus_data = ($urandom % 2) ? m_c1 : 16'($urandom);
                op_issue = ($urandom % 3) == 0;
                flow_flush = ($urandom % 16) == 0;
                instr_boundary = ($urandom % 4) == 0;
                step("R4/R5/R6/R9/R11 random");
            end
        end
        idle_in();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule